// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This unit sits beside a small 8-bit microcontroller core and observes its instruction fetch stream and its data accesses every cycle. When a programmed condition matches, it records which comparator matched and asks the core to stop. It has two comparators on the fetch address and three watchpoints on data traffic.

Each watchpoint is bound to one address space: the register space, with a 7-bit address, the internal data space, with an 8-bit address, or the external data space, with a 16-bit address. It fires on reads, on writes or on both, and it can also require the transferred byte to equal a stored pattern.

The comparators are pure observers. They add no ready signal and no wait state to the core, so normal execution runs unchanged until a hit. The unit is set up through a simple register-write port. It also reports whether the core is running and whether the current access comes from the debugger.

Top module: `dbg_trip_unit`

## Requirements
- R1: After reset `hit_status` is 0, `halt_req` is 0 and every comparator is disabled, so no fetch or access can record a hit until the comparators are configured.
- R2: Config addresses 0 and 1 hold the 16-bit fetch addresses of breakpoints 0 and 1. Config address 2 holds their enable bits, in bits [1:0]. A fetch (`fetch_valid`=1) whose `fetch_pc` equals the address of an enabled breakpoint sets status bit 0 or bit 1 at the next rising clock edge.
- R3: A disabled comparator never records a hit. A breakpoint is disabled when its enable bit is 0. A watchpoint is disabled when its control bit 5 is 0 or when its direction field is 00.
- R4: Config addresses 4, 5 and 6 are the control words of watchpoints 0, 1 and 2. Config addresses 8, 9 and 10 are their 16-bit addresses. Control bits [3:2] select the space that must equal `mem_space`: 00 register space, compared on address bits [6:0]; 01 internal data, compared on bits [7:0]; 10 external data, compared on bits [15:0]; 11 matches nothing. A watchpoint hit sets status bit 2, 3 or 4 at the next rising clock edge.
- R5: Control bits [1:0] select the direction: 01 fires on reads (`mem_write`=0), 10 on writes, 11 on both, and 00 on neither.
- R6: When control bit 4 is 1, a watchpoint fires only if `mem_data` equals the pattern in control bits [15:8]. When control bit 4 is 0, any data value matches.
- R7: An access with `mem_dbg`=1 never triggers a watchpoint.
- R8: Status bits are sticky. `halt_req` rises at the same clock edge as the first status bit and stays high while any status bit is set. Writing to config address 3 clears each status bit whose data bit is 1 and leaves the other bits unchanged. If a hit and a clear of the same bit occur in the same cycle, the hit wins.
- R9: `code_run` is high exactly when `cpu_stopped` is low. `dbg_access` is high in the same cycle as any access with `mem_valid`=1 and `mem_dbg`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_addr | input | 4 | Config register address |
| cfg_wdata | input | 16 | Config write data |
| fetch_valid | input | 1 | Instruction fetch in this cycle |
| fetch_pc | input | 16 | Fetch address |
| mem_valid | input | 1 | Data access in this cycle |
| mem_dbg | input | 1 | Access is driven by the debugger |
| mem_space | input | 2 | Space of the access: 00 register, 01 internal, 10 external |
| mem_write | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 16 | Access address |
| mem_data | input | 8 | Byte transferred |
| cpu_stopped | input | 1 | Core is halted |
| halt_req | output | 1 | Stop request to the core |
| hit_status | output | 5 | Sticky hits: [1:0] breakpoints, [4:2] watchpoints |
| code_run | output | 1 | Core is executing |
| dbg_access | output | 1 | Debugger access in progress |

## Verification
A comparator that decodes the space, the direction or the data option wrongly shows up as a wrong bit in `hit_status`. That bit appears one clock after the access that should or should not have matched. The bench therefore sweeps every combination of space, direction, data option, access kind and partial address overlap on one watchpoint, and compares the status after each single access. A status latch that loses stickiness, or that lets a clear win over a new hit, shows up at `halt_req` within one clock. Bit placement for the other comparators is checked by firing them alone and together.

// File: rtl/dbg_trip_pkg.sv
package dbg_trip_pkg;

  localparam int XA_W     = 16;
  localparam int DW       = 8;
  localparam int SFR_AW   = 7;
  localparam int IDATA_AW = 8;

  typedef enum logic [1:0] {
    SPC_SFR   = 2'b00,
    SPC_IDATA = 2'b01,
    SPC_XDATA = 2'b10,
    SPC_NONE  = 2'b11
  } space_e;

  // config map
  localparam int CFG_BPA_BASE = 0;
  localparam int CFG_BPEN     = 2;
  localparam int CFG_CLR      = 3;
  localparam int CFG_WPC_BASE = 4;
  localparam int CFG_WPA_BASE = 8;

  typedef struct packed {
    logic            en;
    logic            dmatch;
    logic [1:0]      space;
    logic [1:0]      dir;
    logic [DW-1:0]   pattern;
    logic [XA_W-1:0] addr;
  } wp_cfg_t;

  // address compare width depends on the bound space
  function automatic logic addr_hit(input logic [1:0] sp,
                                    input logic [XA_W-1:0] want,
                                    input logic [XA_W-1:0] got);
    logic r;
    case (sp)
      SPC_SFR:   r = (want[SFR_AW-1:0] == got[SFR_AW-1:0]);
      SPC_IDATA: r = (want[IDATA_AW-1:0] == got[IDATA_AW-1:0]);
      SPC_XDATA: r = (want == got);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  // bit 0 of dir enables reads, bit 1 writes
  function automatic logic dir_hit(input logic [1:0] dir, input logic is_wr);
    return is_wr ? dir[1] : dir[0];
  endfunction

  function automatic logic data_hit(input logic need, input logic [DW-1:0] pat,
                                    input logic [DW-1:0] got);
    return !need || (pat == got);
  endfunction

endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs
  import dbg_trip_pkg::*;
#(
  parameter int NUM_BP = 2,
  parameter int NUM_WP = 3,
  parameter int PC_W   = 16,
  parameter int CFG_AW = 4,
  parameter int CW     = 16,
  localparam int HITS  = NUM_BP + NUM_WP
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [CW-1:0]                cfg_wdata,
  output logic [NUM_BP-1:0][PC_W-1:0]  bp_addr,
  output logic [NUM_BP-1:0]            bp_en,
  output wp_cfg_t [NUM_WP-1:0]         wp_cfg,
  output logic [HITS-1:0]              clr_mask
);

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bpa
    always_ff @(posedge clk) begin
      if (!rst_n)
        bp_addr[i] <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(CFG_BPA_BASE + i))
        bp_addr[i] <= cfg_wdata[PC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bp_en <= '0;
    else if (cfg_we && cfg_addr == CFG_AW'(CFG_BPEN))
      bp_en <= cfg_wdata[NUM_BP-1:0];
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp_cfg[j] <= '0;
      end else if (cfg_we && cfg_addr == CFG_AW'(CFG_WPC_BASE + j)) begin
        wp_cfg[j].dir     <= cfg_wdata[1:0];
        wp_cfg[j].space   <= cfg_wdata[3:2];
        wp_cfg[j].dmatch  <= cfg_wdata[4];
        wp_cfg[j].en      <= cfg_wdata[5];
        wp_cfg[j].pattern <= cfg_wdata[8 +: DW];
      end else if (cfg_we && cfg_addr == CFG_AW'(CFG_WPA_BASE + j)) begin
        wp_cfg[j].addr    <= cfg_wdata[XA_W-1:0];
      end
    end
  end

  always_comb begin
    clr_mask = '0;
    if (cfg_we && cfg_addr == CFG_AW'(CFG_CLR))
      clr_mask = cfg_wdata[HITS-1:0];
  end

endmodule

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp #(
  parameter int PC_W = 16
) (
  input  logic            en,
  input  logic [PC_W-1:0] target,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            hit
);
  always_comb hit = en && fetch_valid && (fetch_pc == target);
endmodule

// File: rtl/dbg_wp_cmp.sv
module dbg_wp_cmp
  import dbg_trip_pkg::*;
(
  input  wp_cfg_t          cfg,
  input  logic             mem_valid,
  input  logic             mem_dbg,
  input  logic [1:0]       mem_space,
  input  logic             mem_write,
  input  logic [XA_W-1:0]  mem_addr,
  input  logic [DW-1:0]    mem_data,
  output logic             hit
);
  logic cpu_access;
  logic space_ok;
  logic addr_ok;
  logic dir_ok;
  logic data_ok;

  always_comb begin
    cpu_access = mem_valid && !mem_dbg;
    space_ok   = (mem_space == cfg.space);
    addr_ok    = addr_hit(cfg.space, cfg.addr, mem_addr);
    dir_ok     = dir_hit(cfg.dir, mem_write);
    data_ok    = data_hit(cfg.dmatch, cfg.pattern, mem_data);
    hit        = cfg.en && cpu_access && space_ok && addr_ok && dir_ok && data_ok;
  end
endmodule

// File: rtl/dbg_hit_latch.sv
module dbg_hit_latch #(
  parameter int HITS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HITS-1:0] hits,
  input  logic [HITS-1:0] clr_mask,
  output logic [HITS-1:0] status,
  output logic            halt_req
);
  logic [HITS-1:0] status_n;

  // a new hit overrides a clear of the same bit
  always_comb status_n = (status & ~clr_mask) | hits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= '0;
      halt_req <= 1'b0;
    end else begin
      status   <= status_n;
      halt_req <= |status_n;
    end
  end
endmodule

// File: rtl/dbg_trip_unit.sv
module dbg_trip_unit
  import dbg_trip_pkg::*;
#(
  parameter int NUM_BP = 2,
  parameter int NUM_WP = 3,
  parameter int PC_W   = 16,
  parameter int CFG_AW = 4,
  parameter int CW     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [CW-1:0]              cfg_wdata,
  input  logic                       fetch_valid,
  input  logic [PC_W-1:0]            fetch_pc,
  input  logic                       mem_valid,
  input  logic                       mem_dbg,
  input  logic [1:0]                 mem_space,
  input  logic                       mem_write,
  input  logic [XA_W-1:0]            mem_addr,
  input  logic [DW-1:0]              mem_data,
  input  logic                       cpu_stopped,
  output logic                       halt_req,
  output logic [NUM_BP+NUM_WP-1:0]   hit_status,
  output logic                       code_run,
  output logic                       dbg_access
);
  localparam int HITS = NUM_BP + NUM_WP;

  logic [NUM_BP-1:0][PC_W-1:0] bp_addr;
  logic [NUM_BP-1:0]           bp_en;
  wp_cfg_t [NUM_WP-1:0]        wp_cfg;
  logic [HITS-1:0]             clr_mask;
  logic [NUM_BP-1:0]           bp_hit;
  logic [NUM_WP-1:0]           wp_hit;

  dbg_cfg_regs #(
    .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .PC_W(PC_W), .CFG_AW(CFG_AW), .CW(CW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bp_addr(bp_addr), .bp_en(bp_en),
    .wp_cfg(wp_cfg), .clr_mask(clr_mask)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    dbg_bp_cmp #(.PC_W(PC_W)) u_bp (
      .en(bp_en[i]), .target(bp_addr[i]), .fetch_valid(fetch_valid),
      .fetch_pc(fetch_pc), .hit(bp_hit[i])
    );
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    dbg_wp_cmp u_wp (
      .cfg(wp_cfg[j]), .mem_valid(mem_valid), .mem_dbg(mem_dbg),
      .mem_space(mem_space), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_data(mem_data), .hit(wp_hit[j])
    );
  end

  dbg_hit_latch #(.HITS(HITS)) u_latch (
    .clk(clk), .rst_n(rst_n), .hits({wp_hit, bp_hit}), .clr_mask(clr_mask),
    .status(hit_status), .halt_req(halt_req)
  );

  always_comb begin
    code_run   = !cpu_stopped;
    dbg_access = mem_valid && mem_dbg;
  end

endmodule

// File: rtl/dbg_trip_chk.sv
module dbg_trip_chk #(
  parameter int NUM_BP = 2,
  parameter int NUM_WP = 3,
  parameter int CFG_AW = 4,
  parameter int CW     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic [CFG_AW-1:0]         cfg_addr,
  input logic [CW-1:0]             cfg_wdata,
  input logic                      mem_valid,
  input logic                      mem_dbg,
  input logic [NUM_BP-1:0]         bp_en,
  input logic [NUM_BP-1:0]         bp_hit,
  input logic [NUM_WP-1:0]         wp_hit,
  input logic [NUM_BP+NUM_WP-1:0]  hit_status,
  input logic                      halt_req
);
  localparam int HITS = NUM_BP + NUM_WP;
  localparam logic [CFG_AW-1:0] CLR_A = CFG_AW'(dbg_trip_pkg::CFG_CLR);

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    AST_BP_HIT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit[i] |=> hit_status[i]); // R2
    AST_BP_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bp_en[i] |-> !bp_hit[i]); // R3
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    AST_WP_HIT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      wp_hit[j] |=> hit_status[NUM_BP+j]); // R4
  end

  AST_DBG_NO_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_dbg) |-> (wp_hit == '0)); // R7

  for (genvar k = 0; k < HITS; k++) begin : g_st
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_status[k] && !(cfg_we && cfg_addr == CLR_A && cfg_wdata[k])) |=> hit_status[k]); // R8
  end

  AST_HALT_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req == (|hit_status)); // R8

  AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past((|bp_hit) || (|wp_hit))); // R8

endmodule

bind dbg_trip_unit dbg_trip_chk #(
  .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .CFG_AW(CFG_AW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .mem_valid(mem_valid), .mem_dbg(mem_dbg),
  .bp_en(bp_en), .bp_hit(bp_hit), .wp_hit(wp_hit),
  .hit_status(hit_status), .halt_req(halt_req)
);

// File: tb/tb_dbg_trip_unit.sv
module tb_dbg_trip_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic        mem_valid = 1'b0;
  logic        mem_dbg = 1'b0;
  logic [1:0]  mem_space = '0;
  logic        mem_write = 1'b0;
  logic [15:0] mem_addr = '0;
  logic [7:0]  mem_data = '0;
  logic        cpu_stopped = 1'b0;
  logic        halt_req;
  logic [4:0]  hit_status;
  logic        code_run;
  logic        dbg_access;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbg_trip_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .mem_valid(mem_valid), .mem_dbg(mem_dbg), .mem_space(mem_space),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_data(mem_data),
    .cpu_stopped(cpu_stopped), .halt_req(halt_req), .hit_status(hit_status),
    .code_run(code_run), .dbg_access(dbg_access)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    cfg_wr(4'd3, 16'h001F);
  endtask

  task automatic fetch(input logic [15:0] pc, input logic v);
    @(negedge clk);
    fetch_valid = v; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic access(input logic [1:0] sp, input logic wr, input logic [15:0] a,
                        input logic [7:0] d, input logic dbg);
    @(negedge clk);
    mem_valid = 1'b1; mem_space = sp; mem_write = wr; mem_addr = a;
    mem_data = d; mem_dbg = dbg;
    @(negedge clk);
    mem_valid = 1'b0; mem_dbg = 1'b0;
  endtask

  function automatic logic [15:0] wp_ctrl(int sp, int dir, bit en, bit dm, logic [7:0] pat);
    return {pat, 2'b00, en, dm, 2'(sp), 2'(dir)};
  endfunction

  // independent reference for one watchpoint
  function automatic bit wp_expect(int sp, int dir, bit en, bit dm, logic [7:0] pat,
                                   logic [15:0] wa, int asp, bit wr,
                                   logic [15:0] aa, logic [7:0] ad, bit dbg);
    logic [15:0] m;
    bit dir_ok;
    if (sp == 0) m = 16'h007F;
    else if (sp == 1) m = 16'h00FF;
    else if (sp == 2) m = 16'hFFFF;
    else return 1'b0;
    dir_ok = wr ? (dir == 2 || dir == 3) : (dir == 1 || dir == 3);
    return en && !dbg && (sp == asp) && dir_ok && ((wa & m) == (aa & m)) &&
           (!dm || ad == pat);
  endfunction

  initial begin
    #1_000_000ns;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] xmask [3];
    xmask[0] = 16'h0000; xmask[1] = 16'h0100; xmask[2] = 16'h0080;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", 32'(hit_status), 0);
    check("R1 halt", 32'(halt_req), 0);
    fetch(16'h0000, 1'b1);
    access(2'b00, 1'b0, 16'h0000, 8'h00, 1'b0);
    check("R1 disabled after reset", 32'(hit_status), 0);

    // R2 breakpoints
    cfg_wr(4'd0, 16'h1234);
    cfg_wr(4'd1, 16'hBEEF);
    cfg_wr(4'd2, 16'h0003);
    fetch(16'h1234, 1'b1);
    check("R2 bp0 status", 32'(hit_status), 32'h01);
    check("R2 bp0 halt", 32'(halt_req), 1);
    clear_all();
    fetch(16'hBEEF, 1'b1);
    check("R2 bp1 status", 32'(hit_status), 32'h02);
    clear_all();
    fetch(16'h1235, 1'b1);
    check("R2 near miss", 32'(hit_status), 0);
    fetch(16'h1234, 1'b0);
    check("R2 no fetch strobe", 32'(hit_status), 0);
    // R3 disabled breakpoint
    cfg_wr(4'd2, 16'h0002);
    fetch(16'h1234, 1'b1);
    check("R3 bp0 disabled", 32'(hit_status), 0);
    cfg_wr(4'd2, 16'h0000);

    // R4 R5 R6 sweep on watchpoint 0
    cfg_wr(4'd8, 16'hA5C3);
    for (int sp = 0; sp < 4; sp++)
      for (int dir = 0; dir < 4; dir++)
        for (int dm = 0; dm < 2; dm++) begin
          cfg_wr(4'd4, wp_ctrl(sp, dir, 1'b1, dm[0], 8'h5A));
          for (int asp = 0; asp < 3; asp++)
            for (int wr = 0; wr < 2; wr++)
              for (int deq = 0; deq < 2; deq++)
                for (int av = 0; av < 3; av++) begin
                  logic [15:0] aa;
                  logic [7:0]  ad;
                  bit e;
                  aa = 16'hA5C3 ^ xmask[av];
                  ad = deq ? 8'h5A : 8'h5B;
                  e = wp_expect(sp, dir, 1'b1, dm[0], 8'h5A, 16'hA5C3, asp, wr[0], aa, ad, 1'b0);
                  access(2'(asp), wr[0], aa, ad, 1'b0);
                  check("R4 R5 R6 wp0 sweep", 32'(hit_status), e ? 32'h04 : 32'h00);
                  check("R8 halt follows sweep", 32'(halt_req), 32'(e));
                  if (e) clear_all();
                end
        end

    // R3 watchpoint enable bit off
    cfg_wr(4'd4, wp_ctrl(2, 3, 1'b0, 1'b0, 8'h00));
    access(2'b10, 1'b1, 16'hA5C3, 8'h00, 1'b0);
    check("R3 wp0 disabled", 32'(hit_status), 0);

    // R4 watchpoints 1 and 2 bit positions
    cfg_wr(4'd9, 16'h0042);
    cfg_wr(4'd5, wp_ctrl(1, 2, 1'b1, 1'b0, 8'h00));
    access(2'b01, 1'b1, 16'h0042, 8'h11, 1'b0);
    check("R4 wp1 bit", 32'(hit_status), 32'h08);
    clear_all();
    cfg_wr(4'd10, 16'h0013);
    cfg_wr(4'd6, wp_ctrl(0, 1, 1'b1, 1'b1, 8'h77));
    access(2'b00, 1'b0, 16'h0013, 8'h77, 1'b0);
    check("R4 wp2 bit", 32'(hit_status), 32'h10);
    clear_all();

    // R7 debugger access ignored, R9 dbg_access
    cfg_wr(4'd4, wp_ctrl(2, 3, 1'b1, 1'b0, 8'h00));
    @(negedge clk);
    mem_valid = 1'b1; mem_space = 2'b10; mem_write = 1'b1;
    mem_addr = 16'hA5C3; mem_dbg = 1'b1;
    #1;
    check("R9 dbg_access high", 32'(dbg_access), 1);
    @(negedge clk);
    mem_valid = 1'b0; mem_dbg = 1'b0;
    #1;
    check("R9 dbg_access low", 32'(dbg_access), 0);
    check("R7 debugger access no hit", 32'(hit_status), 0);

    // R8 sticky, partial clear, simultaneous hits
    cfg_wr(4'd2, 16'h0001);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 16'h1234;
    mem_valid = 1'b1; mem_space = 2'b10; mem_write = 1'b0; mem_addr = 16'hA5C3;
    @(negedge clk);
    fetch_valid = 1'b0; mem_valid = 1'b0;
    check("R8 two hits same cycle", 32'(hit_status), 32'h05);
    repeat (5) @(negedge clk);
    check("R8 sticky", 32'(hit_status), 32'h05);
    cfg_wr(4'd3, 16'h0004);
    check("R8 partial clear", 32'(hit_status), 32'h01);
    check("R8 halt held", 32'(halt_req), 1);
    cfg_wr(4'd3, 16'h0001);
    check("R8 cleared", 32'(hit_status), 0);
    check("R8 halt dropped", 32'(halt_req), 0);
    // hit wins over clear in same cycle
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 16'h1234;
    cfg_we = 1'b1; cfg_addr = 4'd3; cfg_wdata = 16'h001F;
    @(negedge clk);
    fetch_valid = 1'b0; cfg_we = 1'b0;
    check("R8 hit beats clear", 32'(hit_status), 32'h01);
    clear_all();
    check("R8 later clear", 32'(hit_status), 0);

    // R9 code_run
    cpu_stopped = 1'b1;
    #1;
    check("R9 code_run stopped", 32'(code_run), 0);
    cpu_stopped = 1'b0;
    #1;
    check("R9 code_run running", 32'(code_run), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule